// File: doc/BRIEF.md
# Memory Socket Sizing and Bank Decode Registers

This block is the configuration face of a memory controller with six module sockets. Static strap inputs give each socket's module size. Software reads a byte that shows which sockets hold 32 MB modules and a byte that shows which sockets are empty. Software then programs eight bank end-address entries through one shared size port. Each write turns the neighbouring entries into a base address and an enable for one socket. At reset, a strap can instead lay out all populated sockets back to back from address zero.

A second, purely combinational path takes a physical address and returns a one-hot socket select, a hit flag and the byte offset inside the selected module. It uses the base and enable state held in the block. Units are 8 MB throughout.

Top module: `mem_bank_regs`

## Requirements
- R1: A read of port 0x803 returns a byte with bit n (n = 0..5) set when socket n holds a 32 MB module. Bits 7:6 are 0. Strap code per socket n is `size_code[2n+1:2n]`: 2'b01 means 8 MB, 2'b10 means 32 MB, and any other code means empty.
- R2: A read of port 0x804 returns 0xFF with bit n cleared for each populated socket n. The same read sets the size-port read index to 0.
- R3: A write to port 0x820 stores `io_wdata[4:0]` into entry `io_wdata[7:5]`.
- R4: A read of port 0x820 returns {3'b000, entry[index]}, and the index then advances by one modulo 8. A write to port 0x820 does not move the index.
- R5: A write of value v to entry k, with 1 ≤ k ≤ 6 and socket k-1 populated, sets start = entry[k-1] (or 0 when k = 1). It sets socket k-1's base to start × 8 MB and enables that socket only when v ≠ start.
- R6: Writes to entry 0, to entry 7, or to an entry whose lower socket is empty store the value and leave every socket's base and enable unchanged.
- R7: A read of port 0x841 returns 0x01.
- R8: With `auto_cfg` high during reset, every populated socket is enabled, and the sockets are placed contiguously from address 0 in socket order.
- R9: With `auto_cfg` low during reset, every socket is disabled, all entries are 0, the index is 0 and `io_rdata` is 0.
- R10: An address hits socket s when s is enabled and base ≤ address < base + size. `sel` is one-hot, `hit` is set, and `offset` = address − base.
- R11: When the windows of several enabled sockets contain the address, the socket with the highest index is selected.
- R12: A read of any other port returns 0xFF. A write to any other port changes no entry or mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_cfg | input | 1 | Strap: contiguous layout at reset |
| size_code | input | 12 | Per-socket module size straps, 2 bits each |
| io_addr | input | 12 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, held until the next read |
| phys_addr | input | ADDR_W | Physical address to decode |
| sel | output | 6 | One-hot socket select |
| hit | output | 1 | Address falls in an enabled socket |
| offset | output | UNIT_LG+2 | Byte offset inside the selected module |

## Verification
Read data is registered on the edge that samples `io_rd`. It can be checked from the falling edge after that strobe until the next read. A write changes entries, bases and enables on the edge that samples `io_wr`, so the decode outputs show the new mapping from the following falling edge. The address decode itself has no register: the bench drives `phys_addr` at a falling edge and samples a moment later. Every decode sweep covers all 32 unit positions against a mapping that the bench recomputes arithmetically from its own copy of the write rules.

// File: rtl/mem_bank_regs.sv
module mem_bank_regs #(
  parameter int ADDR_W  = 32,
  parameter int UNIT_LG = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 auto_cfg,
  input  logic [11:0]          size_code,
  input  logic [11:0]          io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 io_rd,
  input  logic                 io_wr,
  output logic [7:0]           io_rdata,
  input  logic [ADDR_W-1:0]    phys_addr,
  output logic [5:0]           sel,
  output logic                 hit,
  output logic [UNIT_LG+1:0]   offset
);
  localparam int NS = 6;
  localparam int UW = ADDR_W - UNIT_LG;

  logic [4:0] ent [8];
  logic [2:0] idx;
  logic [NS-1:0] en;
  logic [4:0] base [NS];
  logic [4:0] auto_base [NS];
  logic [2:0] sz_u [NS];
  logic [NS-1:0] pop, big;
  logic [7:0] rd_val;

  always_comb begin
    logic [4:0] acc;
    acc = '0;
    for (int s = 0; s < NS; s++) begin
      case (size_code[2*s +: 2])
        2'b01:   sz_u[s] = 3'd1;
        2'b10:   sz_u[s] = 3'd4;
        default: sz_u[s] = 3'd0;
      endcase
      pop[s] = sz_u[s] != 3'd0;
      big[s] = sz_u[s] == 3'd4;
      auto_base[s] = acc;
      acc = acc + {2'b00, sz_u[s]};
    end
  end

  wire rd_pres = io_rd && io_addr == 12'h804;
  wire rd_size = io_rd && io_addr == 12'h820;
  wire wr_size = io_wr && io_addr == 12'h820;
  wire [2:0] wr_k = io_wdata[7:5];
  wire [4:0] wr_v = io_wdata[4:0];
  wire [2:0] low_k = wr_k - 3'd1;
  wire [4:0] start = (wr_k > 3'd1) ? ent[low_k] : 5'd0;
  wire map_upd = wr_size && wr_k >= 3'd1 && wr_k <= 3'd6 && pop[low_k];

  always_comb begin
    case (io_addr)
      12'h803: rd_val = {2'b00, big};
      12'h804: rd_val = {2'b11, ~pop};
      12'h820: rd_val = {3'b000, ent[idx]};
      12'h841: rd_val = 8'h01;
      default: rd_val = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 8; e++) ent[e] <= '0;
      idx      <= '0;
      io_rdata <= '0;
      for (int s = 0; s < NS; s++) begin
        en[s]   <= auto_cfg && pop[s];
        base[s] <= auto_cfg ? auto_base[s] : 5'd0;
      end
    end else begin
      if (io_rd) io_rdata <= rd_val;
      if (rd_size) idx <= idx + 3'd1;
      if (rd_pres) idx <= '0;
      if (wr_size) ent[wr_k] <= wr_v;
      if (map_upd) begin
        en[low_k]   <= wr_v != start;
        base[low_k] <= start;
      end
    end
  end

  wire [UW-1:0] unit = phys_addr[ADDR_W-1:UNIT_LG];
  logic [NS-1:0] in_win;
  logic [2:0] pick;

  always_comb begin
    for (int s = 0; s < NS; s++)
      in_win[s] = en[s] &&
        ({1'b0, unit} >= {{(UW-4){1'b0}}, base[s]}) &&
        ({1'b0, unit} < ({{(UW-4){1'b0}}, base[s]} + {{(UW-2){1'b0}}, sz_u[s]}));
    sel  = '0;
    pick = '0;
    for (int s = 0; s < NS; s++)
      if (in_win[s]) begin
        sel     = '0;
        sel[s]  = 1'b1;
        pick    = 3'(s);
      end
  end

  wire [UW-1:0] diff = unit - {{(UW-5){1'b0}}, base[pick]};
  assign hit    = |in_win;
  assign offset = hit ? {diff[1:0], phys_addr[UNIT_LG-1:0]} : '0;

  // R7
  parity_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 12'h841) |=> io_rdata == 8'h01);

  // R12
  unlisted_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != 12'h803 && io_addr != 12'h804 &&
     io_addr != 12'h820 && io_addr != 12'h841) |=> io_rdata == 8'hFF);

  // R1
  id_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 12'h803) |=> io_rdata[7:6] == 2'b00);

  // R2
  pres_idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pres |=> idx == 3'd0);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_size |=> idx == $past(idx) + 3'd1);

  // R4
  idx_hold_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_rd) |=> $stable(idx));

  // R6
  edge_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_size && (wr_k == 3'd0 || wr_k == 3'd7)) |=> $stable(en));

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && (hit == (sel != 6'd0)));
endmodule

// File: tb/tb_mem_bank_regs.sv
module tb_mem_bank_regs;
  logic clk = 1'b0, rst_n = 1'b0, auto_cfg = 1'b0;
  logic [11:0] size_code = '0, io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] phys_addr = '0;
  logic [5:0] sel;
  logic hit;
  logic [24:0] offset;

  mem_bank_regs dut (.clk, .rst_n, .auto_cfg, .size_code, .io_addr, .io_wdata,
    .io_rd, .io_wr, .io_rdata, .phys_addr, .sel, .hit, .offset);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_ent [8];
  int m_en [6];
  int m_base [6];
  int m_sz [6];

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic do_reset(logic ac, logic [11:0] sc);
    @(negedge clk);
    rst_n = 1'b0; auto_cfg = ac; size_code = sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 8; e++) m_ent[e] = 0;
    for (int s = 0; s < 6; s++) begin
      m_sz[s] = (sc[2*s +: 2] == 2'b01) ? 1 : (sc[2*s +: 2] == 2'b10) ? 4 : 0;
      m_en[s] = 0; m_base[s] = 0;
    end
    if (ac) begin
      int acc = 0;
      for (int s = 0; s < 6; s++) begin
        m_base[s] = acc; m_en[s] = (m_sz[s] != 0); acc += m_sz[s];
      end
    end
  endtask

  task automatic io_read(logic [11:0] a, output int v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic io_write(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic size_write(int k, int v);
    int st;
    st = (k > 1) ? m_ent[k-1] : 0;
    if (k >= 1 && k <= 6 && m_sz[k-1] != 0) begin
      m_en[k-1] = (v != st);
      m_base[k-1] = st;
    end
    m_ent[k] = v;
    io_write(12'h820, 8'((k << 5) | v));
  endtask

  task automatic sweep(string req);
    for (int u = 0; u < 32; u++) begin
      int es, eo;
      logic [22:0] lo;
      lo = 23'((u * 12345 + 77) & 32'h7FFFFF);
      es = -1; eo = 0;
      for (int s = 0; s < 6; s++)
        if (m_en[s] != 0 && u >= m_base[s] && u < m_base[s] + m_sz[s]) begin
          es = s; eo = ((u - m_base[s]) << 23) | int'(lo);
        end
      @(negedge clk);
      phys_addr = {4'(u >> 5), 5'(u), lo};
      #1;
      chk({req, " R10 sel"}, int'(sel), (es < 0) ? 0 : (1 << es));
      chk({req, " R10 hit"}, int'(hit), (es < 0) ? 0 : 1);
      chk({req, " R10 offset"}, int'(offset), eo);
    end
  endtask

  task automatic read_entries(string req);
    int v;
    io_read(12'h804, v);
    for (int e = 0; e < 8; e++) begin
      io_read(12'h820, v);
      chk(req, v, m_ent[e]);
    end
    io_read(12'h820, v);
    chk({req, " R4 wrap"}, v, m_ent[0]);
  endtask

  initial begin
    int v;
    // configuration A: 32,32,8,8,empty,empty
    do_reset(1'b1, 12'h05A);
    chk("R9 rdata after reset", int'(io_rdata), 0);
    io_read(12'h803, v); chk("R1 id A", v, 8'h03);
    io_read(12'h804, v); chk("R2 presence A", v, 8'hF0);
    io_read(12'h841, v); chk("R7 parity", v, 8'h01);
    io_read(12'h900, v); chk("R12 unlisted", v, 8'hFF);
    sweep("R8 auto A");
    // configuration B: 8,empty,empty,empty,32,32
    do_reset(1'b1, 12'hA01);
    io_read(12'h803, v); chk("R1 id B", v, 8'h30);
    io_read(12'h804, v); chk("R2 presence B", v, 8'hCE);
    sweep("R8 auto B");
    // manual programming
    do_reset(1'b0, 12'h05A);
    sweep("R9 manual reset");
    read_entries("R9 entries zero");
    size_write(1, 4); size_write(2, 8); size_write(3, 9); size_write(4, 10);
    size_write(5, 12); size_write(6, 13);
    size_write(0, 17); size_write(7, 30);
    sweep("R5 R6 programmed");
    read_entries("R3 readback");
    io_read(12'h804, v);
    io_read(12'h820, v); chk("R4 first", v, m_ent[0]);
    size_write(7, 30);
    io_read(12'h820, v); chk("R4 no step on write", v, m_ent[1]);
    io_read(12'h804, v);
    io_read(12'h820, v); chk("R2 index cleared", v, m_ent[0]);
    size_write(1, 2); size_write(2, 8);
    sweep("R11 overlap");
    size_write(3, 8);
    sweep("R5 equal disables");
    io_write(12'h821, 8'h3F);
    io_write(12'h803, 8'h5F);
    sweep("R12 write ignored");
    read_entries("R12 entries kept");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule